// File: doc/BRIEF.md
# Four-State Power Mode Controller

This block sequences a chip between four operating states, from full speed down to a fully stopped clock tree. It decides which clock source feeds the system (the fast clock, the slow clock, or none). It also drives separate enables for the CPU clock, the high-speed peripheral clock and the timer/watchdog clock. Software asks for a new state with a one-cycle strobe and a two-bit mode code. A wake-up line from the chip's multi-source wake-up unit brings a sleeping device back to full speed.

The block also produces the slow clock. It is either a 32.768 kHz input from an external crystal, synchronised into the fast domain, or the fast clock divided by a parameter. A strap input chooses between the two and is expected to stay static while the block runs. Moving between the fast and slow sources is sequenced so that the two gates are never open together. The new source opens only after both have been closed for at least two fast cycles and two slow-clock rising edges.

In Power Save the CPU and the timer group keep running on the slow clock, while the high-speed peripheral group stops. In Idle only the timer/watchdog group stays clocked from the slow clock. In Halt every gated clock is off and state is retained. The controller itself always runs on the fast clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Active (`mode_status` = 0), the fast source gate is open, the slow source gate is closed, and the CPU, peripheral and timer enables are all high.
- R2: In settled Active mode (code 0), `fast_src_en`, `cpu_clk_en`, `periph_clk_en` and `timer_clk_en` are high and `slow_src_en` is low; `periph_clk_en` is never high outside Active.
- R3: In settled Power Save mode (code 1), `slow_src_en`, `cpu_clk_en` and `timer_clk_en` are high, while `fast_src_en` and `periph_clk_en` are low.
- R4: In settled Idle mode (code 2), only `slow_src_en` and `timer_clk_en` are high.
- R5: From the second cycle in Halt mode (code 3), all five enables are low.
- R6: `fast_src_en` and `slow_src_en` are never high together. Before either one rises, both have been low for at least two fast cycles, and at least two rising edges of `slow_clk` have occurred in that gap.
- R7: A strobed request for a mode other than the current one is accepted only in Active or Power Save, and `mode_status` shows it on the next cycle. Requests made in Idle or Halt are ignored.
- R8: A request is ignored while a clock source switch is in progress, and a request for the current mode changes nothing.
- R9: `wake` high in Power Save, Idle or Halt sets Active on the next cycle. It takes priority over a request in the same cycle, and has no effect in Active.
- R10: With the divider selected (`slow_ext_sel` = 0), `slow_clk` has a period of `SLOW_DIV` fast cycles at 50 % duty.
- R11: With `slow_ext_sel` = 1, `slow_clk` follows `slow_ext_clk` through a two-stage synchroniser. A change on the input appears on `slow_clk` after two fast clock edges, and not after one.
- R12: While a source switch is in progress, `cpu_clk_en` and `periph_clk_en` are low, starting from the cycle the new mode shows on `mode_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; the controller runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_ext_sel | input | 1 | 1: slow clock from external input; 0: from divider (static strap) |
| slow_ext_clk | input | 1 | External 32.768 kHz clock, asynchronous |
| mode_req_stb | input | 1 | One-cycle request strobe |
| mode_req | input | 2 | Requested mode: 0 Active, 1 Power Save, 2 Idle, 3 Halt |
| wake | input | 1 | Wake-up event from the wake-up unit |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | High-speed peripheral clock enable |
| timer_clk_en | output | 1 | Timer/watchdog group clock enable |
| fast_src_en | output | 1 | System clock uses the fast source (gate open) |
| slow_src_en | output | 1 | System clock uses the slow source (gate open) |
| slow_clk | output | 1 | Slow clock, divided or synchronised external |
| mode_status | output | 2 | Current mode, same coding as `mode_req` |

## Verification
The hardest situation to reach is an event that arrives while a source switch is still waiting out its gap. Examples are a second request landing in the cycle right after one was accepted, or a wake in the same cycle as a request. The bench reaches these by driving back-to-back strobes on consecutive cycles, and by raising `wake` together with a strobe in a settled Power Save state. A monitor measures every gap between the two source gates in fast cycles and in `slow_clk` rising edges. It does this for both the divided clock and the external clock, which the bench toggles by hand to show the synchroniser latency.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SAVE   = 2'd1,
    PM_IDLE   = 2'd2,
    PM_HALT   = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SLOW = 2'd2
  } clk_src_e;

  // clock source each mode needs once settled
  function automatic clk_src_e src_for_mode(pm_mode_e m);
    case (m)
      PM_ACTIVE:        return SRC_FAST;
      PM_SAVE, PM_IDLE: return SRC_SLOW;
      default:          return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pmc_slow_gen.sv
module pmc_slow_gen #(
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic ext_clk,
  output logic slow_clk,
  output logic slow_tick
);
  localparam int HALF = SLOW_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  // divider branch
  logic [CW-1:0] div_cnt;
  logic          div_clk;
  logic          div_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      div_clk  <= 1'b0;
      div_tick <= 1'b0;
    end else if (div_cnt == CW'(HALF - 1)) begin
      div_cnt  <= '0;
      div_clk  <= ~div_clk;
      div_tick <= ~div_clk;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
      div_tick <= 1'b0;
    end
  end

  // external branch: synchroniser plus one edge-detect stage
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  logic ext_lvl, ext_tick;
  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  assign slow_clk  = ext_sel ? ext_lvl  : div_clk;
  assign slow_tick = ext_sel ? ext_tick : div_tick;

endmodule

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_stb,
  input  logic [1:0] req_mode,
  input  logic       wake,
  input  logic       switch_busy,
  output pm_mode_e   mode
);
  logic     run_state;
  logic     req_ok;
  pm_mode_e req_m;

  assign req_m     = pm_mode_e'(req_mode);
  assign run_state = (mode == PM_ACTIVE) || (mode == PM_SAVE);
  assign req_ok    = req_stb && !switch_busy && run_state && (req_m != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode <= PM_ACTIVE;
    else if (wake && mode != PM_ACTIVE)
      mode <= PM_ACTIVE;
    else if (req_ok)
      mode <= req_m;
  end

endmodule

// File: rtl/pmc_clk_switch.sv
module pmc_clk_switch
  import pmc_pkg::*;
#(
  parameter int GAP_FAST = 2,
  parameter int GAP_SLOW = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e target,
  input  logic     slow_tick,
  output logic     fast_en,
  output logic     slow_en,
  output logic     busy
);
  localparam int FW = $clog2(GAP_FAST + 1);
  localparam int SW = $clog2(GAP_SLOW + 1);

  clk_src_e      cur_src;
  logic [FW-1:0] fcnt;
  logic [SW-1:0] scnt;
  logic          gap_done;

  assign gap_done = (fcnt == FW'(GAP_FAST)) && (scnt == SW'(GAP_SLOW));
  assign busy     = (target != cur_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src <= SRC_FAST;
      fast_en <= 1'b1;
      slow_en <= 1'b0;
      fcnt    <= '0;
      scnt    <= '0;
    end else if (busy && cur_src != SRC_NONE) begin
      // close the old gate and restart the gap count
      cur_src <= SRC_NONE;
      fast_en <= 1'b0;
      slow_en <= 1'b0;
      fcnt    <= '0;
      scnt    <= '0;
    end else if (busy && gap_done) begin
      cur_src <= target;
      fast_en <= (target == SRC_FAST);
      slow_en <= (target == SRC_SLOW);
      fcnt    <= '0;
      scnt    <= '0;
    end else if (cur_src == SRC_NONE) begin
      // both gates closed: count the gap, saturating
      if (fcnt != FW'(GAP_FAST))             fcnt <= fcnt + 1'b1;
      if (slow_tick && scnt != SW'(GAP_SLOW)) scnt <= scnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_FAST    = 2,
  parameter int GAP_SLOW    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_ext_sel,
  input  logic       slow_ext_clk,
  input  logic       mode_req_stb,
  input  logic [1:0] mode_req,
  input  logic       wake,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       timer_clk_en,
  output logic       fast_src_en,
  output logic       slow_src_en,
  output logic       slow_clk,
  output logic [1:0] mode_status
);
  pm_mode_e mode;
  logic     slow_tick;
  logic     busy;

  pmc_slow_gen #(
    .SLOW_DIV   (SLOW_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_slow (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (slow_ext_sel),
    .ext_clk  (slow_ext_clk),
    .slow_clk (slow_clk),
    .slow_tick(slow_tick)
  );

  pmc_mode_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_stb    (mode_req_stb),
    .req_mode   (mode_req),
    .wake       (wake),
    .switch_busy(busy),
    .mode       (mode)
  );

  pmc_clk_switch #(
    .GAP_FAST(GAP_FAST),
    .GAP_SLOW(GAP_SLOW)
  ) u_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .target   (src_for_mode(mode)),
    .slow_tick(slow_tick),
    .fast_en  (fast_src_en),
    .slow_en  (slow_src_en),
    .busy     (busy)
  );

  // per-mode gating, held off until the source has settled
  assign cpu_clk_en    = !busy && (mode == PM_ACTIVE || mode == PM_SAVE);
  assign periph_clk_en = !busy && (mode == PM_ACTIVE);
  assign timer_clk_en  = !busy && (mode != PM_HALT);
  assign mode_status   = mode;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic [1:0] mode_status,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       timer_clk_en,
  input logic       fast_src_en,
  input logic       slow_src_en
);
  // R6: gates never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_src_en && slow_src_en));

  // R6: slow gate opens only after fast gate closed two cycles
  a_r6_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_src_en) |-> (!$past(fast_src_en) && !$past(fast_src_en, 2)));

  a_r6_fast_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_src_en) |-> (!$past(slow_src_en) && !$past(slow_src_en, 2)));

  // R5: Halt keeps everything dark after its first cycle
  a_r5_halt_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == PM_HALT && $past(mode_status) == PM_HALT) |->
      !(fast_src_en || slow_src_en || cpu_clk_en || periph_clk_en || timer_clk_en));

  // R9: wake returns to Active next cycle
  a_r9_wake_active: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && mode_status != PM_ACTIVE) |=> mode_status == PM_ACTIVE);

  // R7: no exit from Idle/Halt without wake
  a_r7_deep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_status == PM_IDLE || mode_status == PM_HALT) && !wake) |=> $stable(mode_status));

  // R2: peripheral clock only in Active on the fast source
  a_r2_periph_fast: assert property (@(posedge clk) disable iff (!rst_n)
    periph_clk_en |-> (mode_status == PM_ACTIVE && fast_src_en));

  // R12: CPU runs only on an open source
  a_r12_cpu_sourced: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (fast_src_en || slow_src_en));

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake         (wake),
  .mode_status  (mode_status),
  .cpu_clk_en   (cpu_clk_en),
  .periph_clk_en(periph_clk_en),
  .timer_clk_en (timer_clk_en),
  .fast_src_en  (fast_src_en),
  .slow_src_en  (slow_src_en)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int DIV      = 8;
  localparam int EXT_HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel = 1'b0, ext_clk = 1'b0, ext_run = 1'b0;
  logic stb = 1'b0, wake = 1'b0;
  logic [1:0] req = 2'd0;
  logic cpu, per, tmr, fen, sen, sclk;
  logic [1:0] mode;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.SLOW_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .slow_ext_sel(ext_sel), .slow_ext_clk(ext_clk),
    .mode_req_stb(stb), .mode_req(req), .wake(wake),
    .cpu_clk_en(cpu), .periph_clk_en(per), .timer_clk_en(tmr),
    .fast_src_en(fen), .slow_src_en(sen), .slow_clk(sclk), .mode_status(mode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // enables packed {cpu,per,tmr,fen,sen}
  function automatic int en_vec();
    return {27'd0, cpu, per, tmr, fen, sen};
  endfunction

  task automatic check_en(input string tag, input int exp);
    check(en_vec() == exp, tag, en_vec(), exp);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [1:0] m);
    stb = 1'b1; req = m;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // gap monitor for R6
  int gap_f = 0, gap_s = 0, last_gf = 0, last_gs = 0, overlap = 0;
  logic prev_s = 1'b0, prev_any = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fen && !sen) begin
        gap_f++;
        if (sclk && !prev_s) gap_s++;
      end else begin
        if (!prev_any) begin last_gf = gap_f; last_gs = gap_s; end
        gap_f = 0; gap_s = 0;
      end
      if (fen && sen) overlap++;
      prev_any = fen | sen;
    end
    prev_s = sclk;
  end

  // external slow clock source
  int ecnt = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ecnt++;
      if (ecnt == EXT_HALF) begin ext_clk = ~ext_clk; ecnt = 0; end
    end
  end

  task automatic check_gap(input string tag);
    check(last_gf >= 2, {tag, " gap fast cycles"}, last_gf, 2);
    check(last_gs >= 2, {tag, " gap slow edges"}, last_gs, 2);
  endtask

  task automatic t_reset();
    check(mode == 2'd0, "R1 mode", mode, 0);
    check_en("R1 enables", 5'b11110);
  endtask

  task automatic t_divider();
    int hi = 0, per_len = 0;
    while (!(sclk && !prev_s)) @(negedge clk);
    @(negedge clk);
    per_len = 1; hi = 1;
    while (!(sclk && !prev_s)) begin
      if (sclk) hi++;
      per_len++;
      @(negedge clk);
    end
    check(per_len == DIV, "R10 period", per_len, DIV);
    check(hi == DIV / 2, "R10 high time", hi, DIV / 2);
  endtask

  task automatic t_same_mode();
    request(2'd0);
    check(mode == 2'd0, "R8 same-mode mode", mode, 0);
    check_en("R8 same-mode enables", 5'b11110);
    cycles(5);
    check_en("R8 same-mode later", 5'b11110);
  endtask

  task automatic t_to_save();
    request(2'd1);
    check(mode == 2'd1, "R7 accept next cycle", mode, 1);
    check(cpu == 1'b0 && per == 1'b0, "R12 cpu/per off in switch", {cpu, per}, 0);
    cycles(40);
    check_en("R3 save enables", 5'b10101);
    check_gap("R6 fast->slow");
  endtask

  task automatic t_to_idle();
    request(2'd2);
    check(mode == 2'd2, "R7 save->idle", mode, 2);
    check_en("R4 idle enables", 5'b00101);
  endtask

  task automatic t_idle_ignore();
    request(2'd0);
    cycles(3);
    check(mode == 2'd2, "R7 idle request ignored", mode, 2);
    check_en("R7 idle enables kept", 5'b00101);
  endtask

  task automatic t_wake_idle();
    pulse_wake();
    check(mode == 2'd0, "R9 wake from idle", mode, 0);
    cycles(40);
    check_en("R2 active enables", 5'b11110);
    check_gap("R6 slow->fast");
  endtask

  task automatic t_busy_req();
    request(2'd1);
    request(2'd3);
    cycles(40);
    check(mode == 2'd1, "R8 request during switch ignored", mode, 1);
    check_en("R8 save settled", 5'b10101);
  endtask

  task automatic t_wake_priority();
    stb = 1'b1; req = 2'd2; wake = 1'b1;
    @(negedge clk);
    stb = 1'b0; wake = 1'b0;
    check(mode == 2'd0, "R9 wake beats request", mode, 0);
    cycles(40);
    check_en("R9 back to active", 5'b11110);
    pulse_wake();
    check(mode == 2'd0, "R9 wake ignored in active", mode, 0);
    check_en("R9 active unchanged", 5'b11110);
  endtask

  task automatic t_halt();
    request(2'd3);
    check(mode == 2'd3, "R7 active->halt", mode, 3);
    @(negedge clk);
    check_en("R5 halt dark", 5'b00000);
    request(2'd1);
    cycles(20);
    check(mode == 2'd3, "R7 halt request ignored", mode, 3);
    check_en("R5 halt still dark", 5'b00000);
    pulse_wake();
    check(mode == 2'd0, "R9 wake from halt", mode, 0);
    cycles(10);
    check_en("R2 active after halt", 5'b11110);
    check_gap("R6 halt->fast");
  endtask

  task automatic t_ext();
    ext_sel = 1'b1; ext_clk = 1'b0;
    cycles(5);
    check(sclk == 1'b0, "R11 ext low", sclk, 0);
    ext_clk = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0, "R11 not after one edge", sclk, 0);
    @(negedge clk);
    check(sclk == 1'b1, "R11 after two edges", sclk, 1);
    ext_run = 1'b1;
    request(2'd1);
    cycles(100);
    check_en("R3 save on external", 5'b10101);
    check_gap("R6 fast->ext slow");
    pulse_wake();
    cycles(100);
    check_en("R2 active from external", 5'b11110);
    check_gap("R6 ext slow->fast");
    ext_run = 1'b0;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_same_mode();
    t_to_save();
    t_to_idle();
    t_idle_ignore();
    t_wake_idle();
    t_busy_req();
    t_wake_priority();
    t_halt();
    t_ext();
    check(overlap == 0, "R6 no gate overlap", overlap, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule